// File: doc/BRIEF.md
# Integer ALU with Single Condition Bit

This block is the integer execution stage of a small RISC core whose only condition state is one bit, called T here. It has no flag register; each class of operation says exactly what T receives. Arithmetic can carry the T value in and send a carry, borrow or overflow out. Compares and tests set or clear T. Single-bit shifts and rotates move the bit that falls off into T.

Each cycle the core may present an operation code, two 32-bit operands (`rn`, `rm`), an 8-bit immediate and the current T. One clock edge later the block returns the 32-bit result, a result write-enable, the next T and a T write-enable. The register file and the status register use these enables to decide what to commit. Multiply, divide steps and memory read-modify-write are handled elsewhere.

Top module: `tflag_alu`

## Requirements
- R1: After reset, `res` is 0, `res_we` is 0, `t_we` is 0 and `t_out` is 0.
- R2: The outputs register the operation presented on the previous rising edge. When `op_valid` was low, both write-enables are 0, `res` holds its value and `t_out` equals the previous `t_in`.
- R3: Codes 0 to 8 write a result. The codes are: 0 add (rn+rm); 1 add of the sign-extended immediate (rn+sext(imm)); 2 add with carry (rn+rm+T); 4 subtract (rn−rm); 5 subtract with borrow (rn−rm−T); 7 negate (0−rm); 8 negate with borrow (0−rm−T). Codes 2, 5 and 8 write the carry-out or borrow-out to T. Codes 0, 1, 4 and 7 do not write T.
- R4: Code 3 writes rn+rm and code 6 writes rn−rm. Both write T=1 exactly when the signed result overflowed.
- R5: Compares write T and no result. T is 1 when the condition holds and 0 otherwise. The codes are: 9 rn==rm; 10 rn≥rm unsigned; 11 rn≥rm signed; 12 rn>rm unsigned; 13 rn>rm signed; 14 rn≥0 signed; 15 rn>0 signed; 17 rn==sext(imm).
- R6: Code 16 writes no result and sets T when at least one of the four byte lanes of rn equals the same lane of rm.
- R7: Code 18 tests rn&rm and code 19 tests rn&zext(imm). Neither writes a result. Both set T exactly when the AND is zero.
- R8: Code 20 writes rn−1 and sets T exactly when that new value is zero.
- R9: These codes write a result and leave T alone: 21 rn&rm; 22 rn|rm; 23 rn^rm; 24 ~rm; 25 rm sign-extended from bit 7; 26 rm sign-extended from bit 15; 27 rm zero-extended from bit 7; 28 rm zero-extended from bit 15.
- R10: Code 29 exchanges bits [7:0] and [15:8] of rm and keeps bits [31:16]. Code 30 exchanges the two halves of rm. Code 31 returns bits [47:16] of the 64-bit value {rm,rn}. None of them writes T.
- R11: Rotates act on rn. Code 32 rotates left by one and code 33 rotates right by one; each puts the bit that moves around into T. Code 34 rotates left through T and code 35 rotates right through T: the old T enters the vacated end and the bit that leaves goes to T.
- R12: Shifts act on rn by one bit. Codes 36 and 38 shift left with 0 fill and put the old bit 31 into T. Code 37 shifts right and keeps bit 31. Code 39 shifts right with 0 fill. Codes 37 and 39 put the old bit 0 into T.
- R13: Every operation that does not write T (codes 0, 1, 4, 7, 21–31) gives `t_we`=0 and `t_out` equal to the input T. Codes 40–63 write neither the result nor T.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 6 | Operation code (see requirements) |
| rn | input | 32 | First operand; destination-side register |
| rm | input | 32 | Second operand |
| imm | input | 8 | Immediate field |
| t_in | input | 1 | Current T bit |
| res | output | 32 | Registered result |
| res_we | output | 1 | Result is to be written |
| t_out | output | 1 | Next T bit |
| t_we | output | 1 | T is to be written |

## Verification
The assertions assume that `op_valid`, `op_code` and `t_in` are known and stable around each rising edge, and that `t_in` is the architectural T at that edge. The bench meets this by driving every input on the falling edge. It randomises every code in 0–63, including unused codes and idle cycles, with T chosen at random. Directed cases cover the carry, borrow and overflow wrap points, a compare with a single matching byte lane, and a decrement to zero.

// File: rtl/tflag_alu.sv
module tflag_alu #(
  parameter int W   = 32,
  parameter int OPW = 6,
  parameter int IW  = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           op_valid,
  input  logic [OPW-1:0] op_code,
  input  logic [W-1:0]   rn,
  input  logic [W-1:0]   rm,
  input  logic [IW-1:0]  imm,
  input  logic           t_in,
  output logic [W-1:0]   res,
  output logic           res_we,
  output logic           t_out,
  output logic           t_we
);
  localparam int H  = W / 2;
  localparam int NB = W / 8;

  localparam logic [OPW-1:0] OP_ADD = 0,  OP_ADDI = 1,  OP_ADDC = 2,  OP_ADDV = 3,
    OP_SUB = 4,  OP_SUBC = 5,  OP_SUBV = 6,  OP_NEG = 7,  OP_NEGC = 8,
    OP_CEQ = 9,  OP_CHS = 10,  OP_CGE = 11,  OP_CHI = 12,  OP_CGT = 13,
    OP_CPZ = 14, OP_CPL = 15,  OP_CSTR = 16, OP_CEQI = 17, OP_TST = 18,
    OP_TSTI = 19, OP_DT = 20,  OP_AND = 21,  OP_OR = 22,   OP_XOR = 23,
    OP_NOT = 24, OP_XSB = 25,  OP_XSW = 26,  OP_XUB = 27,  OP_XUW = 28,
    OP_SWB = 29, OP_SWW = 30,  OP_XTR = 31,  OP_ROL = 32,  OP_ROR = 33,
    OP_RCL = 34, OP_RCR = 35,  OP_SAL = 36,  OP_SAR = 37,  OP_SLL = 38,
    OP_SLR = 39;

  wire [W-1:0] simm = {{(W-IW){imm[IW-1]}}, imm};
  wire [W-1:0] zimm = {{(W-IW){1'b0}}, imm};
  wire [W:0]   tw   = {{W{1'b0}}, t_in};

  wire [W:0]   add_x = {1'b0, rn} + {1'b0, rm} + tw;
  wire [W:0]   sub_x = {1'b0, rn} - {1'b0, rm} - tw;
  wire [W:0]   neg_x = {(W+1){1'b0}} - {1'b0, rm} - tw;
  wire [W-1:0] sum   = rn + rm;
  wire [W-1:0] dif   = rn - rm;
  wire [W-1:0] dec   = rn - {{(W-1){1'b0}}, 1'b1};
  wire         ovf_a = (rn[W-1] == rm[W-1]) && (sum[W-1] != rn[W-1]);
  wire         ovf_s = (rn[W-1] != rm[W-1]) && (dif[W-1] != rn[W-1]);

  logic [NB-1:0] lane_eq;
  for (genvar b = 0; b < NB; b++) begin : g_lane
    assign lane_eq[b] = rn[8*b +: 8] == rm[8*b +: 8];
  end

  logic [W-1:0] nres;
  logic nrwe, nt, ntwe;

  always_comb begin
    nres = '0; nrwe = 1'b1; nt = t_in; ntwe = 1'b0;
    case (op_code)
      OP_ADD:  nres = sum;
      OP_ADDI: nres = rn + simm;
      OP_ADDC: begin nres = add_x[W-1:0]; nt = add_x[W]; ntwe = 1'b1; end
      OP_ADDV: begin nres = sum; nt = ovf_a; ntwe = 1'b1; end
      OP_SUB:  nres = dif;
      OP_SUBC: begin nres = sub_x[W-1:0]; nt = sub_x[W]; ntwe = 1'b1; end
      OP_SUBV: begin nres = dif; nt = ovf_s; ntwe = 1'b1; end
      OP_NEG:  nres = '0 - rm;
      OP_NEGC: begin nres = neg_x[W-1:0]; nt = neg_x[W]; ntwe = 1'b1; end
      OP_CEQ:  begin nrwe = 1'b0; ntwe = 1'b1; nt = rn == rm; end
      OP_CHS:  begin nrwe = 1'b0; ntwe = 1'b1; nt = rn >= rm; end
      OP_CGE:  begin nrwe = 1'b0; ntwe = 1'b1; nt = $signed(rn) >= $signed(rm); end
      OP_CHI:  begin nrwe = 1'b0; ntwe = 1'b1; nt = rn > rm; end
      OP_CGT:  begin nrwe = 1'b0; ntwe = 1'b1; nt = $signed(rn) > $signed(rm); end
      OP_CPZ:  begin nrwe = 1'b0; ntwe = 1'b1; nt = !rn[W-1]; end
      OP_CPL:  begin nrwe = 1'b0; ntwe = 1'b1; nt = !rn[W-1] && (rn != '0); end
      OP_CSTR: begin nrwe = 1'b0; ntwe = 1'b1; nt = |lane_eq; end
      OP_CEQI: begin nrwe = 1'b0; ntwe = 1'b1; nt = rn == simm; end
      OP_TST:  begin nrwe = 1'b0; ntwe = 1'b1; nt = (rn & rm) == '0; end
      OP_TSTI: begin nrwe = 1'b0; ntwe = 1'b1; nt = (rn & zimm) == '0; end
      OP_DT:   begin nres = dec; nt = dec == '0; ntwe = 1'b1; end
      OP_AND:  nres = rn & rm;
      OP_OR:   nres = rn | rm;
      OP_XOR:  nres = rn ^ rm;
      OP_NOT:  nres = ~rm;
      OP_XSB:  nres = {{(W-8){rm[7]}}, rm[7:0]};
      OP_XSW:  nres = {{(W-16){rm[15]}}, rm[15:0]};
      OP_XUB:  nres = {{(W-8){1'b0}}, rm[7:0]};
      OP_XUW:  nres = {{(W-16){1'b0}}, rm[15:0]};
      OP_SWB:  nres = {rm[W-1:16], rm[7:0], rm[15:8]};
      OP_SWW:  nres = {rm[H-1:0], rm[W-1:H]};
      OP_XTR:  nres = {rm[H-1:0], rn[W-1:H]};
      OP_ROL:  begin nres = {rn[W-2:0], rn[W-1]}; nt = rn[W-1]; ntwe = 1'b1; end
      OP_ROR:  begin nres = {rn[0], rn[W-1:1]};   nt = rn[0];   ntwe = 1'b1; end
      OP_RCL:  begin nres = {rn[W-2:0], t_in};    nt = rn[W-1]; ntwe = 1'b1; end
      OP_RCR:  begin nres = {t_in, rn[W-1:1]};    nt = rn[0];   ntwe = 1'b1; end
      OP_SAL, OP_SLL:
               begin nres = {rn[W-2:0], 1'b0};    nt = rn[W-1]; ntwe = 1'b1; end
      OP_SAR:  begin nres = {rn[W-1], rn[W-1:1]}; nt = rn[0];   ntwe = 1'b1; end
      OP_SLR:  begin nres = {1'b0, rn[W-1:1]};    nt = rn[0];   ntwe = 1'b1; end
      default: nrwe = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res <= '0; res_we <= 1'b0; t_out <= 1'b0; t_we <= 1'b0;
    end else begin
      res_we <= op_valid && nrwe;
      t_we   <= op_valid && ntwe;
      t_out  <= (op_valid && ntwe) ? nt : t_in;
      if (op_valid && nrwe) res <= nres;
    end
  end

  wire is_cmp  = op_code >= OP_CEQ && op_code <= OP_TSTI;
  wire no_t_op = op_code == OP_ADD || op_code == OP_ADDI || op_code == OP_SUB ||
                 op_code == OP_NEG || (op_code >= OP_AND && op_code <= OP_XTR);

  assert_idle_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> !res_we && !t_we && $stable(res) && t_out == $past(t_in));
  assert_cmp_no_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && is_cmp |=> t_we && !res_we);
  assert_dt_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_DT |=> res_we && t_we && (t_out == (res == '0)));
  assert_t_kept_R13: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && no_t_op |=> !t_we && res_we && t_out == $past(t_in));
  assert_unused_code_R13: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code > OP_SLR |=> !res_we && !t_we);
  assert_rotc_in_R11: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op_code == OP_RCL |=> res[0] == $past(t_in) && t_out == $past(rn[W-1]));
endmodule

// File: tb/tflag_alu_bench.sv
module tflag_alu_bench;
  logic clk = 0, rst_n = 0, op_valid = 0, t_in = 0;
  logic [5:0] op_code = 0;
  logic [31:0] rn = 0, rm = 0;
  logic [7:0] imm = 0;
  logic [31:0] res;
  logic res_we, t_out, t_we;
  int total = 0, bad = 0;

  always #5 clk = ~clk;

  tflag_alu u_tflag_alu (.clk, .rst_n, .op_valid, .op_code, .rn, .rm, .imm, .t_in,
                         .res, .res_we, .t_out, .t_we);

  typedef struct packed { logic [31:0] r; logic rwe; logic t; logic twe; } exp_t;
  exp_t  q[$];
  string tq[$];

  function automatic string tag_of(logic v, logic [5:0] c);
    if (!v) return "R2";
    if (c == 3 || c == 6) return "R4";
    if (c <= 8) return "R3";
    if (c == 16) return "R6";
    if (c <= 17) return "R5";
    if (c <= 19) return "R7";
    if (c == 20) return "R8";
    if (c <= 28) return "R9";
    if (c <= 31) return "R10";
    if (c <= 35) return "R11";
    if (c <= 39) return "R12";
    return "R13";
  endfunction

  function automatic exp_t model(logic v, logic [5:0] c, logic [31:0] a, logic [31:0] b,
                                 logic [7:0] i, logic t);
    exp_t e; logic [32:0] w; logic [31:0] si;
    si = {{24{i[7]}}, i};
    e.r = 0; e.rwe = 1; e.t = t; e.twe = 0;
    if (!v) begin e.rwe = 0; return e; end
    case (c)
      0: e.r = a + b;
      1: e.r = a + si;
      2: begin w = 33'(a) + 33'(b) + 33'(t); e.r = w[31:0]; e.t = w[32]; e.twe = 1; end
      3: begin e.r = a + b; e.twe = 1;
           e.t = ($signed(a) + 64'sd0 + $signed(b)) > 64'sd2147483647 ||
                 ($signed(a) + 64'sd0 + $signed(b)) < -64'sd2147483648; end
      4: e.r = a - b;
      5: begin e.r = a - b - 32'(t); e.t = (33'(b) + 33'(t)) > 33'(a); e.twe = 1; end
      6: begin e.r = a - b; e.twe = 1;
           e.t = ($signed(a) + 64'sd0 - $signed(b)) > 64'sd2147483647 ||
                 ($signed(a) + 64'sd0 - $signed(b)) < -64'sd2147483648; end
      7: e.r = 0 - b;
      8: begin e.r = 0 - b - 32'(t); e.t = (b != 0) || t; e.twe = 1; end
      9:  begin e.rwe = 0; e.twe = 1; e.t = a == b; end
      10: begin e.rwe = 0; e.twe = 1; e.t = a >= b; end
      11: begin e.rwe = 0; e.twe = 1; e.t = $signed(a) >= $signed(b); end
      12: begin e.rwe = 0; e.twe = 1; e.t = a > b; end
      13: begin e.rwe = 0; e.twe = 1; e.t = $signed(a) > $signed(b); end
      14: begin e.rwe = 0; e.twe = 1; e.t = $signed(a) >= 0; end
      15: begin e.rwe = 0; e.twe = 1; e.t = $signed(a) > 0; end
      16: begin e.rwe = 0; e.twe = 1; e.t = 0;
            for (int k = 0; k < 4; k++) if (a[8*k +: 8] == b[8*k +: 8]) e.t = 1; end
      17: begin e.rwe = 0; e.twe = 1; e.t = a == si; end
      18: begin e.rwe = 0; e.twe = 1; e.t = (a & b) == 0; end
      19: begin e.rwe = 0; e.twe = 1; e.t = (a & {24'd0, i}) == 0; end
      20: begin e.r = a - 1; e.t = (a == 1); e.twe = 1; end
      21: e.r = a & b;
      22: e.r = a | b;
      23: e.r = a ^ b;
      24: e.r = ~b;
      25: e.r = 32'($signed(b[7:0]));
      26: e.r = 32'($signed(b[15:0]));
      27: e.r = {24'd0, b[7:0]};
      28: e.r = {16'd0, b[15:0]};
      29: e.r = {b[31:16], b[7:0], b[15:8]};
      30: e.r = {b[15:0], b[31:16]};
      31: e.r = 32'({b, a} >> 16);
      32: begin e.r = (a << 1) | (a >> 31); e.t = a[31]; e.twe = 1; end
      33: begin e.r = (a >> 1) | (a << 31); e.t = a[0]; e.twe = 1; end
      34: begin e.r = (a << 1) | 32'(t); e.t = a[31]; e.twe = 1; end
      35: begin e.r = (a >> 1) | (32'(t) << 31); e.t = a[0]; e.twe = 1; end
      36, 38: begin e.r = a << 1; e.t = a[31]; e.twe = 1; end
      37: begin e.r = 32'($signed(a) >>> 1); e.t = a[0]; e.twe = 1; end
      39: begin e.r = a >> 1; e.t = a[0]; e.twe = 1; end
      default: e.rwe = 0;
    endcase
    return e;
  endfunction

  task automatic drive(logic v, logic [5:0] c, logic [31:0] a, logic [31:0] b,
                       logic [7:0] i, logic t);
    @(negedge clk);
    op_valid = v; op_code = c; rn = a; rm = b; imm = i; t_in = t;
    q.push_back(model(v, c, a, b, i, t));
    tq.push_back(tag_of(v, c));
  endtask

  logic [31:0] last_res = 0;
  initial begin
    forever begin
      @(posedge clk); #1;
      if (q.size() > 0) begin
        exp_t e; string tg; logic ok;
        e = q.pop_front(); tg = tq.pop_front();
        if (e.rwe) last_res = e.r;
        ok = res_we == e.rwe && t_we == e.twe && t_out == e.t && res == last_res;
        total++;
        if (!ok) begin
          bad++;
          $display("FAIL %s op=%0d got res=%h we=%b t=%b twe=%b exp res=%h we=%b t=%b twe=%b",
                   tg, op_code, res, res_we, t_out, t_we, last_res, e.rwe, e.t, e.twe);
        end
      end
    end
  end

  initial begin
    repeat (3) @(posedge clk); #1;
    total++;
    if (res !== 0 || res_we !== 0 || t_we !== 0 || t_out !== 0) begin
      bad++; $display("FAIL R1 reset got res=%h we=%b t=%b twe=%b exp 0 0 0 0", res, res_we, t_out, t_we);
    end
    @(negedge clk); rst_n = 1;
    drive(1, 2, 32'hFFFFFFFF, 0, 0, 1);           // R3 carry wrap
    drive(1, 5, 0, 0, 0, 1);                       // R3 borrow wrap
    drive(1, 8, 0, 0, 0, 0);                       // R3 negate zero, no borrow
    drive(1, 1, 10, 0, 8'hFF, 0);                  // R3 sext imm
    drive(1, 3, 32'h7FFFFFFF, 1, 0, 0);            // R4
    drive(1, 6, 32'h80000000, 1, 0, 0);            // R4
    drive(1, 11, 32'hFFFFFFFF, 1, 0, 1);           // R5 signed
    drive(1, 10, 32'hFFFFFFFF, 1, 0, 0);           // R5 unsigned
    drive(1, 15, 0, 0, 0, 1);                      // R5 zero not positive
    drive(1, 16, 32'h12345678, 32'hAB34CDEF, 0, 0);// R6 one lane
    drive(1, 16, 32'h12345678, 32'h21436587, 0, 1);// R6 no lane
    drive(1, 19, 32'h100, 0, 8'hFF, 0);            // R7 zext
    drive(1, 20, 1, 0, 0, 0);                      // R8 to zero
    drive(1, 20, 0, 0, 0, 1);                      // R8 wrap
    drive(1, 31, 32'h11112222, 32'h33334444, 0, 0);// R10
    drive(1, 34, 32'h80000000, 0, 0, 1);           // R11
    drive(1, 35, 32'h1, 0, 0, 0);                  // R11
    drive(1, 37, 32'h80000001, 0, 0, 0);           // R12
    drive(1, 25, 0, 32'h80, 0, 1);                 // R9 and R13 keep T
    drive(0, 2, 1, 1, 0, 1);                       // R2 idle
    drive(1, 50, 1, 2, 3, 1);                      // R13 unused code
    for (int n = 0; n < 3000; n++) begin
      logic [31:0] a, b;
      a = $urandom; b = $urandom;
      if (n % 4 == 0) b = a;
      if (n % 7 == 0) b[15:8] = a[15:8];
      drive(($urandom % 8) != 0, 6'($urandom), a, b, 8'($urandom), 1'($urandom));
    end
    @(negedge clk); op_valid = 0;
    repeat (3) @(posedge clk); #2;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule